// File: doc/BRIEF.md
# Sequenced DMA Transfer Queue Controller

This block is the memory-mapped DMA front end of one processing hart. Software writes a source address, a destination address and a byte count into parameter registers, then writes the control register with bit 0 set. That write takes a copy of the three parameters, gives the copy a sequence number, and pushes it into a bounded queue. A word mover takes queued transfers one at a time, in queue order. It copies each one 64 bits at a time over a generic memory port, from the source region to the destination region. Completion is published as a completed-sequence count that only rises.

Software can poll the completed count until it reaches the number of its transfer. It can also write that number to the completed-sequence register, and the bus write then stalls until the transfer has finished. A start write also stalls when every slot is taken. A register access is one cycle with `reg_req` held high, extended for as long as `reg_ready` is low.

The mover's state machine has five states. MV_IDLE moves to MV_CHECK when the queue is not empty, and pops the head into working registers. MV_CHECK moves to MV_FINISH when the remaining count is zero and to MV_READ otherwise. MV_READ stays put until the port grants, latches the read word and moves to MV_WRITE. MV_WRITE stays put until the port grants. It then moves to MV_FINISH if this was the last word, and back to MV_READ otherwise with both addresses advanced by 8. MV_FINISH publishes the transfer's number as the completed count and returns to MV_IDLE.

Top module: `dma_seq_ctrl`

## Requirements
- R1: After reset, the started-sequence register (byte offset 8) and the completed-sequence register (byte offset 16) read 0, and the control register (byte offset 0) always reads 0.
- R2: The source (offset 24), destination (offset 32) and size (offset 40) registers read back what was written. An offset that is not a multiple of 8, or any offset from 48 to 255, reads 0, and a write there changes no register.
- R3: A write to offset 0 with bit 0 set is accepted as a start, and the started-sequence register then reads the ID given to it. IDs are 1, 2, 3 and so on, one per accepted start. A control write with bit 0 clear starts nothing.
- R4: Each start copies the parameter registers, so later writes to source, destination or size do not alter a transfer already started.
- R5: A transfer of N bytes issues ceil(N/8) writes. Write k goes to destination+8k and carries the word read from source+8k. Every write has all 8 byte enables set except the last word of a size that is not a multiple of 8, which enables only the low (N mod 8) bytes; bit i of `mem_be` enables `mem_wdata` byte i.
- R6: A transfer of size 0 completes without any memory access.
- R7: Transfers complete in start order. The completed count equals the ID of the last finished transfer, never decreases, and never exceeds the last started ID.
- R8: A write of an ID to offset 16 holds `reg_ready` low until the completed count is at least that ID. If it already is, the write completes at once.
- R9: With DEPTH transfers queued and one in the mover, a further start write holds `reg_ready` low until a slot frees. Up to DEPTH+1 starts are accepted without a stall.
- R10: The mover writes a word only after the read of that word was granted. While a memory request is not granted, the request, its direction, address and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, held until ready |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset in the register window |
| reg_wdata | input | 64 | Register write data |
| reg_ready | output | 1 | Access completes in this cycle |
| reg_rdata | output | 64 | Read data, valid when ready |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables for writes |
| mem_gnt | input | 1 | Access taken in this cycle |
| mem_rdata | input | 64 | Read data, valid in the granted cycle |

## Verification
The hardest situation to reach is the full queue, where a start write must stall. It needs DEPTH transfers waiting and one more held in the mover, all at the same moment. The bench gets there by holding the memory grant low, so the mover is stuck on its first read. It then issues DEPTH+1 starts that must all pass without a stall, and then one more whose stall is measured while a parallel branch releases the grant 20 cycles later. The copy of parameters at start is checked by rewriting them right after a start with a partial-word size. A size-0 start follows, and every granted write is compared against writes the bench predicted from its own copy of the parameters.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int ADDR_W    = 64;
    localparam int SIZE_W    = 32;
    localparam int ID_W      = 32;
    localparam int BUS_W     = 64;
    localparam int BE_W      = BUS_W / 8;
    localparam int REG_OFS_W = 8;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [SIZE_W-1:0] size;
    } xfer_desc_t;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_CHECK,
        MV_READ,
        MV_WRITE,
        MV_FINISH
    } mv_state_t;
endpackage

// File: rtl/dma_desc_fifo.sv
module dma_desc_fifo
    import dma_seq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  xfer_desc_t push_desc,
    input  logic       pop,
    output xfer_desc_t head_desc,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    xfer_desc_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_desc;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + CNT_W'(1);
            end else if (pop && !push) begin
                count <= count - CNT_W'(1);
            end
        end
    end

    assign head_desc = slots[rd_ptr];
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [REG_OFS_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]     reg_wdata,
    output logic                 reg_ready,
    output logic [BUS_W-1:0]     reg_rdata,
    input  logic                 queue_full,
    input  logic [ID_W-1:0]      done_id,
    output logic                 push,
    output xfer_desc_t           push_desc,
    output logic [ID_W-1:0]      started_id
);
    localparam int IDX_W = REG_OFS_W - 3;
    localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_START = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_DONE  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_SRC   = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_DST   = IDX_W'(4);
    localparam logic [IDX_W-1:0] IDX_SIZE  = IDX_W'(5);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [SIZE_W-1:0] size_q;
    logic [ID_W-1:0]   next_id;
    logic [IDX_W-1:0]  idx;
    logic              aligned;
    logic              wr_hit;
    logic              start_req;
    logic              wait_req;

    assign idx       = reg_addr[REG_OFS_W-1:3];
    assign aligned   = (reg_addr[2:0] == 3'd0);
    assign wr_hit    = reg_req && reg_we && aligned;
    assign start_req = wr_hit && (idx == IDX_CTRL) && reg_wdata[0];
    assign wait_req  = wr_hit && (idx == IDX_DONE);
    assign push      = start_req && !queue_full;

    always_comb begin
        if (start_req) begin
            reg_ready = !queue_full;
        end else if (wait_req) begin
            reg_ready = (done_id >= reg_wdata[ID_W-1:0]);
        end else begin
            reg_ready = 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            unique case (idx)
                IDX_START: reg_rdata = BUS_W'(started_id);
                IDX_DONE:  reg_rdata = BUS_W'(done_id);
                IDX_SRC:   reg_rdata = BUS_W'(src_q);
                IDX_DST:   reg_rdata = BUS_W'(dst_q);
                IDX_SIZE:  reg_rdata = BUS_W'(size_q);
                default:   reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q      <= '0;
            dst_q      <= '0;
            size_q     <= '0;
            started_id <= '0;
            next_id    <= ID_W'(1);
        end else begin
            if (wr_hit && idx == IDX_SRC)  src_q  <= reg_wdata[ADDR_W-1:0];
            if (wr_hit && idx == IDX_DST)  dst_q  <= reg_wdata[ADDR_W-1:0];
            if (wr_hit && idx == IDX_SIZE) size_q <= reg_wdata[SIZE_W-1:0];
            if (push) begin
                started_id <= next_id;
                next_id    <= next_id + ID_W'(1);
            end
        end
    end

    always_comb begin
        push_desc.id   = next_id;
        push_desc.src  = src_q;
        push_desc.dst  = dst_q;
        push_desc.size = size_q;
    end
endmodule

// File: rtl/dma_word_mover.sv
module dma_word_mover
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              queue_empty,
    input  xfer_desc_t        head_desc,
    output logic              pop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_gnt,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic [ID_W-1:0]   done_id
);
    localparam logic [SIZE_W-1:0] STEP = SIZE_W'(BE_W);

    mv_state_t         state;
    mv_state_t         state_nx;
    logic [ID_W-1:0]   cur_id;
    logic [ADDR_W-1:0] cur_src;
    logic [ADDR_W-1:0] cur_dst;
    logic [SIZE_W-1:0] remain;
    logic [BUS_W-1:0]  word_buf;
    logic              last_word;

    assign last_word = (remain <= STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MV_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        pop       = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_src;
        mem_wdata = word_buf;
        mem_be    = '0;
        unique case (state)
            MV_IDLE: begin
                if (!queue_empty) begin
                    pop      = 1'b1;
                    state_nx = MV_CHECK;
                end
            end
            MV_CHECK: begin
                state_nx = (remain == '0) ? MV_FINISH : MV_READ;
            end
            MV_READ: begin
                mem_req = 1'b1;
                if (mem_gnt) state_nx = MV_WRITE;
            end
            MV_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_dst;
                for (int i = 0; i < BE_W; i++) begin
                    mem_be[i] = (remain > SIZE_W'(i));
                end
                if (mem_gnt) state_nx = last_word ? MV_FINISH : MV_READ;
            end
            MV_FINISH: begin
                state_nx = MV_IDLE;
            end
            default: state_nx = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id   <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            remain   <= '0;
            word_buf <= '0;
            done_id  <= '0;
        end else begin
            if (pop) begin
                cur_id  <= head_desc.id;
                cur_src <= head_desc.src;
                cur_dst <= head_desc.dst;
                remain  <= head_desc.size;
            end
            if (state == MV_READ && mem_gnt) begin
                word_buf <= mem_rdata;
            end
            if (state == MV_WRITE && mem_gnt) begin
                cur_src <= cur_src + ADDR_W'(BE_W);
                cur_dst <= cur_dst + ADDR_W'(BE_W);
                remain  <= last_word ? '0 : remain - STEP;
            end
            if (state == MV_FINISH) begin
                done_id <= cur_id;
            end
        end
    end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [REG_OFS_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]     reg_wdata,
    output logic                 reg_ready,
    output logic [BUS_W-1:0]     reg_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BUS_W-1:0]     mem_wdata,
    output logic [BE_W-1:0]      mem_be,
    input  logic                 mem_gnt,
    input  logic [BUS_W-1:0]     mem_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    xfer_desc_t       push_desc;
    xfer_desc_t       head_desc;
    logic             push;
    logic             pop;
    logic [CNT_W-1:0] fifo_cnt;
    logic             queue_full;
    logic             queue_empty;
    logic [ID_W-1:0]  started_id;
    logic [ID_W-1:0]  done_id;

    assign queue_full  = (fifo_cnt == CNT_W'(DEPTH));
    assign queue_empty = (fifo_cnt == '0);

    dma_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_ready  (reg_ready),
        .reg_rdata  (reg_rdata),
        .queue_full (queue_full),
        .done_id    (done_id),
        .push       (push),
        .push_desc  (push_desc),
        .started_id (started_id)
    );

    dma_desc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_desc (push_desc),
        .pop       (pop),
        .head_desc (head_desc),
        .count     (fifo_cnt)
    );

    dma_word_mover u_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .queue_empty (queue_empty),
        .head_desc   (head_desc),
        .pop         (pop),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_be      (mem_be),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .done_id     (done_id)
    );
endmodule

// File: rtl/dma_seq_ctrl_chk.sv
module dma_seq_ctrl_chk
    import dma_seq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_req,
    input logic                   reg_we,
    input logic [REG_OFS_W-1:0]   reg_addr,
    input logic [BUS_W-1:0]       reg_wdata,
    input logic                   reg_ready,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [BUS_W-1:0]       mem_wdata,
    input logic                   mem_gnt,
    input logic [ID_W-1:0]        started_id,
    input logic [ID_W-1:0]        done_id,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    AST_DONE_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_id <= started_id); // R7

    AST_DONE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        done_id >= $past(done_id)); // R7

    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (started_id != $past(started_id)) |-> (started_id == $past(started_id) + 1'b1)); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R9

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == 8'd0 && reg_wdata[0]
         && fifo_cnt == ($clog2(DEPTH+1))'(DEPTH)) |-> !reg_ready); // R9

    AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == 8'd16 && done_id < reg_wdata[ID_W-1:0]) |-> !reg_ready); // R8
endmodule

bind dma_seq_ctrl dma_seq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_ready  (reg_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .started_id (started_id),
    .done_id    (done_id),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/dma_seq_ctrl_test.sv
`timescale 1ns/100ps
module dma_seq_ctrl_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_ready;
    logic [63:0] reg_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [63:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_be;
    logic        mem_gnt = 1'b0;
    logic [63:0] mem_rdata;

    always #2.5 clk = ~clk;

    dma_seq_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit reported = 0;
    bit gnt_en = 1'b1;
    logic [7:0] lfsr = 8'h5b;

    typedef struct {
        logic [63:0] addr;
        logic [63:0] data;
        logic [7:0]  be;
    } exp_wr_t;
    exp_wr_t exp_q[$];

    logic [63:0] m_src = '0, m_dst = '0, m_size = '0;
    int m_id = 0;

    function automatic logic [63:0] pat(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A5A_C3C3, (~a[31:0]) + 32'h0101};
    endfunction

    assign mem_rdata = pat(mem_addr);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_gnt = gnt_en && (lfsr[0] || lfsr[2]);
        end
    end

    // every granted memory write against the predicted list (R5, R6, R10)
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_req && mem_we && mem_gnt) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected write", mem_addr, 64'h0);
            end else begin
                exp_wr_t e;
                logic [63:0] m;
                e = exp_q.pop_front();
                for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{e.be[i]}};
                chk(mem_addr == e.addr, "R5 write address", mem_addr, e.addr);
                chk(mem_be == e.be, "R5 byte enables", {56'h0, mem_be}, {56'h0, e.be});
                chk((mem_wdata & m) == (e.data & m), "R10 write data", mem_wdata & m, e.data & m);
            end
        end
    end

    task automatic xact(input bit we, input logic [7:0] a, input logic [63:0] d,
                        output logic [63:0] rd, output int waits);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        waits = 0;
        #1;
        while (!reg_ready) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = reg_rdata;
        @(posedge clk);
        #1;
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        logic [63:0] r; int w;
        xact(1'b1, a, d, r, w);
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] v);
        int w;
        xact(1'b0, a, 64'h0, v, w);
    endtask

    task automatic set_params(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n);
        wr(8'd24, s); m_src = s;
        wr(8'd32, d); m_dst = d;
        wr(8'd40, n); m_size = n;
    endtask

    task automatic start_xfer(input logic [63:0] ctrl, output int waits);
        logic [63:0] r;
        xact(1'b1, 8'd0, ctrl, r, waits);
        if (ctrl[0]) begin
            m_id++;
            for (longint off = 0; off < longint'(m_size); off += 8) begin
                exp_wr_t e;
                longint left;
                left   = longint'(m_size) - off;
                e.addr = m_dst + 64'(off);
                e.data = pat(m_src + 64'(off));
                for (int i = 0; i < 8; i++) e.be[i] = (left > i);
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic poll_done(input int id);
        logic [63:0] v;
        for (int k = 0; k < 3000; k++) begin
            rd(8'd16, v);
            if (v >= 64'(id)) break;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        chk(1'b0, "watchdog", 64'h0, 64'h1);
        report();
        $finish;
    end

    initial begin
        logic [63:0] v;
        int w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'd8, v);  chk(v == 0, "R1 started after reset", v, 0);
        rd(8'd16, v); chk(v == 0, "R1 completed after reset", v, 0);
        rd(8'd0, v);  chk(v == 0, "R1 control reads zero", v, 0);

        // R2 register map
        set_params(64'h1000, 64'h8000, 64'd24);
        rd(8'd24, v); chk(v == 64'h1000, "R2 source readback", v, 64'h1000);
        rd(8'd32, v); chk(v == 64'h8000, "R2 destination readback", v, 64'h8000);
        rd(8'd40, v); chk(v == 64'd24, "R2 size readback", v, 64'd24);
        wr(8'd48, 64'hDEAD); rd(8'd48, v); chk(v == 0, "R2 unmapped 48", v, 0);
        wr(8'd25, 64'hBEEF); rd(8'd25, v); chk(v == 0, "R2 misaligned offset", v, 0);
        rd(8'd248, v); chk(v == 0, "R2 unmapped 248", v, 0);
        rd(8'd24, v); chk(v == 64'h1000, "R2 unmapped write ignored", v, 64'h1000);

        // R3 clear start bit does nothing
        start_xfer(64'h50, w);
        rd(8'd8, v); chk(v == 0, "R3 control without start bit", v, 0);

        // R3 first transfer, R5 full words
        start_xfer(64'h51, w);
        rd(8'd8, v); chk(v == 1, "R3 first ID", v, 1);
        poll_done(1);
        rd(8'd16, v); chk(v == 1, "R7 completed equals last ID", v, 1);

        // R4 copy at start, R5 partial word, R6 size zero
        set_params(64'h2000, 64'h9000, 64'd13);
        start_xfer(64'h1, w);
        set_params(64'h3000, 64'hA000, 64'd0);
        start_xfer(64'h1, w);
        rd(8'd8, v); chk(v == 3, "R3 third ID", v, 3);
        xact(1'b1, 8'd16, 64'd3, v, w);
        chk(w > 0, "R8 wait write stalled", 64'(w), 64'h1);
        rd(8'd16, v); chk(v == 3, "R7 in-order completion", v, 3);
        chk(exp_q.size() == 0, "R4 R6 all predicted writes seen", 64'(exp_q.size()), 0);

        // R9 queue full
        set_params(64'h4000, 64'hB000, 64'd16);
        gnt_en = 1'b0;
        for (int k = 0; k < DEPTH + 1; k++) begin
            start_xfer(64'h1, w);
            chk(w == 0, "R9 start accepted without stall", 64'(w), 0);
        end
        fork
            begin start_xfer(64'h1, w); end
            begin repeat (20) @(negedge clk); gnt_en = 1'b1; end
        join
        chk(w >= 15, "R9 start stalled when full", 64'(w), 64'd20);
        rd(8'd8, v); chk(v == 9, "R3 ID after full", v, 9);
        xact(1'b1, 8'd16, 64'd9, v, w);
        rd(8'd16, v); chk(v == 9, "R7 completed after drain", v, 9);
        xact(1'b1, 8'd16, 64'd5, v, w);
        chk(w == 0, "R8 wait on finished ID", 64'(w), 0);
        chk(exp_q.size() == 0, "R5 every word written", 64'(exp_q.size()), 0);

        report();
        $finish;
    end
endmodule